// File: doc/BRIEF.md
# Interrupt Control and Status Register

This block is a 32-bit host-visible register that sits beside a network controller's interrupt logic. It keeps two sticky event flags, each with its own enable: one records a system bus error seen during a bus-master transfer, the other records an excessive-deferral event from the transmitter. Both flags are cleared by the host writing a one to them. The same word also carries two control bits that decide whether the end of a transmitted frame raises the transmit interrupt: an OK-suppress bit and a last-transmit enable. When the last-transmit enable is set, a per-frame descriptor flag decides the outcome instead.

The block drives an interrupt request built from the flags and their enables. The system-error term reaches the request even when the global interrupt enable is low, because a system error causes a stop elsewhere in the controller, and that stop clears the global enable. It also emits a qualified pulse that tells the interrupt status logic to set the transmit interrupt flag. Three reset sources act differently on the bits: a hard reset, a soft reset and a stop.

Top module: `intr_ctl_csr`

## Requirements
- R1: Readback layout: bit 0 system-error flag, bit 1 system-error enable, bit 2 deferral flag, bit 3 deferral enable, bit 4 OK-suppress, bit 5 last-transmit enable; bits 31:6 always read 0, and writes to them have no effect. Writes load bits 1, 3, 4 and 5 directly.
- R2: A one-cycle pulse on any bit of `bus_err` (bit 0 parity error, bit 1 master abort, bit 2 target abort) sets the system-error flag at the next clock edge.
- R3: Writing 1 to bit 0 or bit 2 clears that flag at the next edge. Writing 0 leaves it unchanged. A write can never set a flag.
- R4: If a flag's set event and a write-1 clear of that flag arrive in the same cycle, the flag ends up set.
- R5: A pulse on `tx_defer_evt` sets the deferral flag at the next edge.
- R6: A soft reset clears the system-error flag, its enable, OK-suppress and last-transmit enable, even when an event or write arrives in the same cycle. It leaves the deferral flag and the deferral enable unchanged.
- R7: Hard reset (asynchronous, active high) clears every bit and has priority over everything else.
- R8: `stop_req` has no effect on any register bit.
- R9: `irq` = (system-error flag AND its enable) OR (`glob_irq_en` AND deferral flag AND deferral enable). It is combinational from the stored bits and `glob_irq_en`.
- R10: `tx_irq_set` = `tx_done` AND (NOT `tx_ok` OR (last-transmit enable ? `tx_desc_last` : NOT OK-suppress)). It is combinational. OK-suppress is ignored while last-transmit enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst | input | 1 | Hard reset, asynchronous, active high |
| soft_rst | input | 1 | Soft reset, synchronous |
| stop_req | input | 1 | Stop request (does not alter this register) |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Register readback |
| bus_err | input | 3 | Bus-master error pulses: parity, master abort, target abort |
| tx_defer_evt | input | 1 | Excessive-deferral pulse from the transmitter |
| tx_done | input | 1 | End-of-frame pulse |
| tx_ok | input | 1 | Frame finished without error (valid with tx_done) |
| tx_desc_last | input | 1 | Last-transmit flag from the frame's descriptor |
| glob_irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| tx_irq_set | output | 1 | Qualified set pulse for the transmit interrupt flag |

## Verification
A bad stored bit shows up on `rd_data` in the cycle after the write, event or reset that caused it. A bad flag or enable also shows up on `irq` with no added delay, because the request is built combinationally from those bits. A wrong OK-suppress or last-transmit bit shows only when a frame ends, as a missing or extra `tx_irq_set` in that same cycle. The bench therefore sweeps every combination of transmit inputs and control bits, and every flag/enable/global-enable combination, sampling right after the edge that stored the state.

// File: rtl/icsr_pkg.sv
package icsr_pkg;
   // Which reset sources clear a stored bit
   typedef enum logic {
      CLR_HARD_ONLY = 1'b0,
      CLR_HARD_SOFT = 1'b1
   } clr_class_e;

   // Index of each control bit inside the control vector
   localparam int CTL_N      = 4;
   localparam int CTL_SYS_EN = 0;
   localparam int CTL_DEF_EN = 1;
   localparam int CTL_OKSUP  = 2;
   localparam int CTL_LTXEN  = 3;
endpackage

// File: rtl/icsr_sticky_flag.sv
module icsr_sticky_flag
   import icsr_pkg::*;
#(
   parameter clr_class_e CLR_CLASS = CLR_HARD_SOFT
) (
   input  logic clk,
   input  logic hrst,
   input  logic soft_rst,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   logic flag_r;

   generate
      if (CLR_CLASS == CLR_HARD_SOFT) begin : g_soft
         always_ff @(posedge clk or posedge hrst) begin
            if (hrst)          flag_r <= 1'b0;
            else if (soft_rst) flag_r <= 1'b0;
            else if (set_i)    flag_r <= 1'b1;
            else if (clr_i)    flag_r <= 1'b0;
         end
      end else begin : g_hard
         logic unused_soft;
         assign unused_soft = soft_rst;
         always_ff @(posedge clk or posedge hrst) begin
            if (hrst)       flag_r <= 1'b0;
            else if (set_i) flag_r <= 1'b1;
            else if (clr_i) flag_r <= 1'b0;
         end
      end
   endgenerate

   assign q = flag_r;
endmodule

// File: rtl/icsr_ctl_reg.sv
module icsr_ctl_reg #(
   parameter int           N        = 4,
   parameter logic [N-1:0] SOFT_CLR = '1
) (
   input  logic         clk,
   input  logic         hrst,
   input  logic         soft_rst,
   input  logic         wr_en,
   input  logic [N-1:0] wr_bits,
   output logic [N-1:0] q
);
   generate
      if (N < 1) begin : g_bad_n
         $error("icsr_ctl_reg: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic bit_r;
         if (SOFT_CLR[i]) begin : g_soft
            always_ff @(posedge clk or posedge hrst) begin
               if (hrst)          bit_r <= 1'b0;
               else if (soft_rst) bit_r <= 1'b0;
               else if (wr_en)    bit_r <= wr_bits[i];
            end
         end else begin : g_hard
            always_ff @(posedge clk or posedge hrst) begin
               if (hrst)       bit_r <= 1'b0;
               else if (wr_en) bit_r <= wr_bits[i];
            end
         end
         assign q[i] = bit_r;
      end
   endgenerate
endmodule

// File: rtl/icsr_tx_qual.sv
module icsr_tx_qual (
   input  logic tx_done,
   input  logic tx_ok,
   input  logic tx_desc_last,
   input  logic ok_sup,
   input  logic ltx_en,
   output logic set_o
);
   logic ok_path;

   always_comb begin
      if (ltx_en) ok_path = tx_desc_last;
      else        ok_path = !ok_sup;
      set_o = tx_done && (!tx_ok || ok_path);
   end
endmodule

// File: rtl/icsr_irq_comb.sv
module icsr_irq_comb #(
   parameter int N_GATED = 1
) (
   input  logic               sys_flag,
   input  logic               sys_en,
   input  logic [N_GATED-1:0] g_flag,
   input  logic [N_GATED-1:0] g_en,
   input  logic               glob_en,
   output logic               irq_o
);
   generate
      if (N_GATED < 1) begin : g_bad_n
         $error("icsr_irq_comb: N_GATED must be at least 1");
      end
   endgenerate

   always_comb begin
      irq_o = (sys_flag && sys_en) || (glob_en && |(g_flag & g_en));
   end
endmodule

// File: rtl/intr_ctl_csr.sv
module intr_ctl_csr
   import icsr_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int ERR_SRC_N    = 3,
   parameter int SYS_FLAG_POS = 0,
   parameter int SYS_EN_POS   = 1,
   parameter int DEF_FLAG_POS = 2,
   parameter int DEF_EN_POS   = 3,
   parameter int OKSUP_POS    = 4,
   parameter int LTXEN_POS    = 5
) (
   input  logic                 clk,
   input  logic                 hrst,
   input  logic                 soft_rst,
   input  logic                 stop_req,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wr_data,
   output logic [DATA_W-1:0]    rd_data,
   input  logic [ERR_SRC_N-1:0] bus_err,
   input  logic                 tx_defer_evt,
   input  logic                 tx_done,
   input  logic                 tx_ok,
   input  logic                 tx_desc_last,
   input  logic                 glob_irq_en,
   output logic                 irq,
   output logic                 tx_irq_set
);
   localparam logic [DATA_W-1:0] ONE_W = {{(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [DATA_W-1:0] USED_MASK =
      (ONE_W << SYS_FLAG_POS) | (ONE_W << SYS_EN_POS) | (ONE_W << DEF_FLAG_POS) |
      (ONE_W << DEF_EN_POS)   | (ONE_W << OKSUP_POS)  | (ONE_W << LTXEN_POS);
   localparam int USED_N = $countones(USED_MASK);
   // Deferral enable survives soft reset; the other control bits do not
   localparam logic [CTL_N-1:0] CTL_SOFT_CLR = ~(4'b0001 << CTL_DEF_EN);

   // Elaboration-time parameter checks
   generate
      if (DATA_W < 8 || DATA_W > 64) begin : g_bad_width
         $error("intr_ctl_csr: DATA_W out of range");
      end
      if (ERR_SRC_N < 1) begin : g_bad_src
         $error("intr_ctl_csr: ERR_SRC_N must be at least 1");
      end
      if (SYS_FLAG_POS >= DATA_W || SYS_EN_POS >= DATA_W || DEF_FLAG_POS >= DATA_W ||
          DEF_EN_POS >= DATA_W || OKSUP_POS >= DATA_W || LTXEN_POS >= DATA_W) begin : g_bad_pos
         $error("intr_ctl_csr: field position outside the word");
      end
      if (USED_N != 6) begin : g_overlap
         $error("intr_ctl_csr: field positions overlap");
      end
   endgenerate

   logic             sys_flag, def_flag;
   logic [CTL_N-1:0] ctl_q, ctl_wr;
   logic             any_bus_err;

   assign any_bus_err = |bus_err;

   // stop_req is an input for completeness; no bit here responds to it
   logic unused_stop;
   assign unused_stop = stop_req;

   // Sticky flags: system error follows both resets, deferral only the hard one
   icsr_sticky_flag #(.CLR_CLASS(CLR_HARD_SOFT)) u_sys_flag (
      .clk      (clk),
      .hrst     (hrst),
      .soft_rst (soft_rst),
      .set_i    (any_bus_err),
      .clr_i    (wr_en && wr_data[SYS_FLAG_POS]),
      .q        (sys_flag)
   );

   icsr_sticky_flag #(.CLR_CLASS(CLR_HARD_ONLY)) u_def_flag (
      .clk      (clk),
      .hrst     (hrst),
      .soft_rst (soft_rst),
      .set_i    (tx_defer_evt),
      .clr_i    (wr_en && wr_data[DEF_FLAG_POS]),
      .q        (def_flag)
   );

   // Control bits, gathered from their word positions
   always_comb begin
      ctl_wr             = '0;
      ctl_wr[CTL_SYS_EN] = wr_data[SYS_EN_POS];
      ctl_wr[CTL_DEF_EN] = wr_data[DEF_EN_POS];
      ctl_wr[CTL_OKSUP]  = wr_data[OKSUP_POS];
      ctl_wr[CTL_LTXEN]  = wr_data[LTXEN_POS];
   end

   icsr_ctl_reg #(.N(CTL_N), .SOFT_CLR(CTL_SOFT_CLR)) u_ctl (
      .clk      (clk),
      .hrst     (hrst),
      .soft_rst (soft_rst),
      .wr_en    (wr_en),
      .wr_bits  (ctl_wr),
      .q        (ctl_q)
   );

   icsr_tx_qual u_tx_qual (
      .tx_done      (tx_done),
      .tx_ok        (tx_ok),
      .tx_desc_last (tx_desc_last),
      .ok_sup       (ctl_q[CTL_OKSUP]),
      .ltx_en       (ctl_q[CTL_LTXEN]),
      .set_o        (tx_irq_set)
   );

   icsr_irq_comb #(.N_GATED(1)) u_irq (
      .sys_flag (sys_flag),
      .sys_en   (ctl_q[CTL_SYS_EN]),
      .g_flag   (def_flag),
      .g_en     (ctl_q[CTL_DEF_EN]),
      .glob_en  (glob_irq_en),
      .irq_o    (irq)
   );

   // Readback; unused positions read zero
   always_comb begin
      rd_data               = '0;
      rd_data[SYS_FLAG_POS] = sys_flag;
      rd_data[SYS_EN_POS]   = ctl_q[CTL_SYS_EN];
      rd_data[DEF_FLAG_POS] = def_flag;
      rd_data[DEF_EN_POS]   = ctl_q[CTL_DEF_EN];
      rd_data[OKSUP_POS]    = ctl_q[CTL_OKSUP];
      rd_data[LTXEN_POS]    = ctl_q[CTL_LTXEN];
   end
endmodule

// File: rtl/intr_ctl_csr_chk.sv
module intr_ctl_csr_chk #(
   parameter int DATA_W       = 32,
   parameter int ERR_SRC_N    = 3,
   parameter int SYS_FLAG_POS = 0,
   parameter int SYS_EN_POS   = 1,
   parameter int DEF_FLAG_POS = 2,
   parameter int DEF_EN_POS   = 3,
   parameter int OKSUP_POS    = 4,
   parameter int LTXEN_POS    = 5
) (
   input logic                 clk,
   input logic                 hrst,
   input logic                 soft_rst,
   input logic                 stop_req,
   input logic                 wr_en,
   input logic [DATA_W-1:0]    wr_data,
   input logic [DATA_W-1:0]    rd_data,
   input logic [ERR_SRC_N-1:0] bus_err,
   input logic                 tx_defer_evt,
   input logic                 tx_done,
   input logic                 tx_ok,
   input logic                 tx_desc_last,
   input logic                 glob_irq_en,
   input logic                 irq,
   input logic                 tx_irq_set
);
   localparam logic [DATA_W-1:0] ONE_W = {{(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [DATA_W-1:0] USED_MASK =
      (ONE_W << SYS_FLAG_POS) | (ONE_W << SYS_EN_POS) | (ONE_W << DEF_FLAG_POS) |
      (ONE_W << DEF_EN_POS)   | (ONE_W << OKSUP_POS)  | (ONE_W << LTXEN_POS);

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (hrst)
      (rd_data & ~USED_MASK) == '0);                                          // R1
   AST_SYS_ERR_SETS: assert property (@(posedge clk) disable iff (hrst)
      (|bus_err) && !soft_rst |=> rd_data[SYS_FLAG_POS]);                     // R2
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (hrst)
      wr_en && wr_data[SYS_FLAG_POS] && !(|bus_err) |=> !rd_data[SYS_FLAG_POS]); // R3
   AST_W0_KEEPS: assert property (@(posedge clk) disable iff (hrst)
      wr_en && !wr_data[DEF_FLAG_POS] && rd_data[DEF_FLAG_POS] |=> rd_data[DEF_FLAG_POS]); // R3
   AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (hrst)
      tx_defer_evt && wr_en && wr_data[DEF_FLAG_POS] |=> rd_data[DEF_FLAG_POS]); // R4
   AST_DEFER_SETS: assert property (@(posedge clk) disable iff (hrst)
      tx_defer_evt |=> rd_data[DEF_FLAG_POS]);                                // R5
   AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (hrst)
      soft_rst |=> !rd_data[SYS_FLAG_POS] && !rd_data[SYS_EN_POS] &&
                   !rd_data[OKSUP_POS] && !rd_data[LTXEN_POS]);               // R6
   AST_SOFT_KEEPS_DEF: assert property (@(posedge clk) disable iff (hrst)
      soft_rst && !tx_defer_evt && !wr_en |=> $stable(rd_data[DEF_FLAG_POS]) &&
                                              $stable(rd_data[DEF_EN_POS]));  // R6
   AST_STOP_NO_EFFECT: assert property (@(posedge clk) disable iff (hrst)
      stop_req && !soft_rst && !wr_en && !(|bus_err) && !tx_defer_evt |=> $stable(rd_data)); // R8
   AST_SYS_IRQ_UNGATED: assert property (@(posedge clk) disable iff (hrst)
      rd_data[SYS_FLAG_POS] && rd_data[SYS_EN_POS] |-> irq);                  // R9
   AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (hrst)
      !(rd_data[SYS_FLAG_POS] && rd_data[SYS_EN_POS]) && !glob_irq_en |-> !irq); // R9
   AST_TX_OK_SUPPRESSED: assert property (@(posedge clk) disable iff (hrst)
      tx_ok && rd_data[OKSUP_POS] && !rd_data[LTXEN_POS] |-> !tx_irq_set);    // R10
   AST_TX_ERR_ALWAYS: assert property (@(posedge clk) disable iff (hrst)
      tx_done && !tx_ok |-> tx_irq_set);                                      // R10
   AST_TX_NEEDS_DONE: assert property (@(posedge clk) disable iff (hrst)
      !tx_done |-> !tx_irq_set);                                              // R10
endmodule

bind intr_ctl_csr intr_ctl_csr_chk #(
   .DATA_W(DATA_W), .ERR_SRC_N(ERR_SRC_N), .SYS_FLAG_POS(SYS_FLAG_POS),
   .SYS_EN_POS(SYS_EN_POS), .DEF_FLAG_POS(DEF_FLAG_POS), .DEF_EN_POS(DEF_EN_POS),
   .OKSUP_POS(OKSUP_POS), .LTXEN_POS(LTXEN_POS)
) u_chk (
   .clk(clk), .hrst(hrst), .soft_rst(soft_rst), .stop_req(stop_req),
   .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .bus_err(bus_err),
   .tx_defer_evt(tx_defer_evt), .tx_done(tx_done), .tx_ok(tx_ok),
   .tx_desc_last(tx_desc_last), .glob_irq_en(glob_irq_en), .irq(irq),
   .tx_irq_set(tx_irq_set)
);

// File: tb/intr_ctl_csr_test.sv
module intr_ctl_csr_test;
   localparam logic [31:0] SF = 32'h01, SE = 32'h02, DF = 32'h04,
                           DE = 32'h08, OS = 32'h10, LT = 32'h20;

   logic        clk = 1'b0;
   logic        hrst = 1'b1;
   logic        soft_rst = 1'b0, stop_req = 1'b0, wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [2:0]  bus_err = '0;
   logic        tx_defer_evt = 1'b0, tx_done = 1'b0, tx_ok = 1'b0, tx_desc_last = 1'b0;
   logic        glob_irq_en = 1'b0;
   logic        irq, tx_irq_set;
   int          n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   intr_ctl_csr uut (
      .clk(clk), .hrst(hrst), .soft_rst(soft_rst), .stop_req(stop_req),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .bus_err(bus_err),
      .tx_defer_evt(tx_defer_evt), .tx_done(tx_done), .tx_ok(tx_ok),
      .tx_desc_last(tx_desc_last), .glob_irq_en(glob_irq_en), .irq(irq),
      .tx_irq_set(tx_irq_set)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      wr_en = 1'b1; wr_data = d; cyc(); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic bus_pulse(input logic [2:0] v);
      bus_err = v; cyc(); bus_err = '0;
   endtask

   task automatic defer_pulse();
      tx_defer_evt = 1'b1; cyc(); tx_defer_evt = 1'b0;
   endtask

   task automatic hard_reset();
      hrst = 1'b1; cyc(); hrst = 1'b0; cyc();
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      cyc(); cyc(); hrst = 1'b0; cyc();
      chk("R7 reset rd_data", rd_data, 32'h0);
      chk("R7 reset irq", {31'b0, irq}, 32'h0);
      chk("R10 idle tx_irq_set", {31'b0, tx_irq_set}, 32'h0);

      // R1 / R3: all-ones write loads controls only; flags and reserved stay 0
      wr(32'hFFFF_FFFF);
      chk("R1 write all ones", rd_data, SE | DE | OS | LT);
      wr(32'hFFFF_FFC0);
      chk("R1 reserved write ignored", rd_data, 32'h0);

      // R2 / R3 / R9: each bus error source
      for (int s = 0; s < 3; s++) begin
         hard_reset();
         wr(SE);
         glob_irq_en = 1'b0;
         bus_pulse(3'b001 << s);
         chk("R2 bus error source sets flag", rd_data, SE | SF);
         #1 chk("R9 system irq ignores global enable", {31'b0, irq}, 32'h1);
         wr(SE);
         chk("R3 write 0 keeps flag", rd_data, SE | SF);
         wr(SE | SF);
         chk("R3 write 1 clears flag", rd_data, SE);
      end

      // R4: set and clear in one cycle, both flags
      hard_reset();
      bus_pulse(3'b010);
      wr_en = 1'b1; wr_data = SF; bus_err = 3'b100; cyc();
      wr_en = 1'b0; wr_data = '0; bus_err = '0;
      chk("R4 system flag set wins", rd_data, SF);
      defer_pulse();
      wr_en = 1'b1; wr_data = DF; tx_defer_evt = 1'b1; cyc();
      wr_en = 1'b0; wr_data = '0; tx_defer_evt = 1'b0;
      chk("R4 deferral flag set wins", rd_data, SF | DF);

      // R5: deferral flag and global gating
      hard_reset();
      wr(DE);
      defer_pulse();
      chk("R5 deferral flag set", rd_data, DE | DF);
      glob_irq_en = 1'b0; #1 chk("R9 deferral gated off", {31'b0, irq}, 32'h0);
      glob_irq_en = 1'b1; #1 chk("R9 deferral gated on", {31'b0, irq}, 32'h1);
      cyc();
      wr(DF | DE);
      chk("R3 deferral write 1 clears", rd_data, DE);
      glob_irq_en = 1'b0;

      // R6: soft reset with a same-cycle event
      hard_reset();
      wr(SE | DE | OS | LT);
      bus_pulse(3'b001);
      defer_pulse();
      chk("R6 setup all bits", rd_data, 32'h3F);
      soft_rst = 1'b1; bus_err = 3'b001; cyc();
      soft_rst = 1'b0; bus_err = '0;
      chk("R6 soft reset keeps only deferral bits", rd_data, DF | DE);

      // R8: stop changes nothing
      wr(SE | DE | OS | LT);
      bus_pulse(3'b100);
      stop_req = 1'b1; cyc(); cyc(); stop_req = 1'b0;
      chk("R8 stop leaves register", rd_data, 32'h3F);

      // R7: hard reset clears all
      hard_reset();
      chk("R7 hard reset clears", rd_data, 32'h0);

      // R9: sweep flags, enables and global enable
      for (int m = 0; m < 32; m++) begin
         logic sf_b, se_b, df_b, de_b, g_b, exp_irq;
         sf_b = m[0]; se_b = m[1]; df_b = m[2]; de_b = m[3]; g_b = m[4];
         hard_reset();
         wr((se_b ? SE : 32'h0) | (de_b ? DE : 32'h0));
         if (sf_b) bus_pulse(3'b010);
         if (df_b) defer_pulse();
         glob_irq_en = g_b;
         exp_irq = (sf_b & se_b) | (g_b & df_b & de_b);
         #1 chk("R9 irq sweep", {31'b0, irq}, {31'b0, exp_irq});
         cyc();
      end
      glob_irq_en = 1'b0;

      // R10: sweep transmit qualification
      for (int m = 0; m < 32; m++) begin
         logic d_b, ok_b, ds_b, os_b, lt_b, exp_set;
         d_b = m[0]; ok_b = m[1]; ds_b = m[2]; os_b = m[3]; lt_b = m[4];
         wr((os_b ? OS : 32'h0) | (lt_b ? LT : 32'h0));
         tx_done = d_b; tx_ok = ok_b; tx_desc_last = ds_b;
         exp_set = d_b & (~ok_b | (lt_b ? ds_b : ~os_b));
         #1 chk("R10 tx set sweep", {31'b0, tx_irq_set}, {31'b0, exp_set});
         cyc();
         tx_done = 1'b0; tx_ok = 1'b0; tx_desc_last = 1'b0;
      end

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule